// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to a two-wire I2C bus and turns the activity it sees into a stream of one-cycle event records. It never drives the bus. The SCL and SDA levels arrive as sampled inputs together with a sample-valid strobe. They pass through a two-flop synchroniser, and line transitions are judged only on samples where the strobe is high.

The monitor recognises START, repeated START and STOP conditions. It gathers each byte as eight bits, most significant first, followed by the acknowledge bit. Every byte is labelled as an address or data transfer and as a read or a write. Each record carries a 3-bit event code, a byte value, a NACK flag and the raw received byte, all qualified by a single-cycle valid pulse.

A typical use is a trace or debug unit that records bus traffic without taking part in it.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset `evt_vld` is 0. The first valid sample only loads the stored previous SCL/SDA levels, so no event comes from that sample, even when SDA is already low with SCL high.
- R2: While idle (searching for a START), SDA going 1 to 0 on two consecutive valid samples with SCL high on the later one gives event code 0 (START), with `evt_byte`, `evt_raw` and `evt_nack` all 0. In this state, SCL rises and SDA rising with SCL high produce nothing.
- R3: A bit is taken on each valid sample where SCL was 0 on the previous valid sample and is 1 on this one. Bits shift in MSB-first. Each byte is 8 bits plus a 9th acknowledge bit, and `evt_raw` reports the 8 shifted bits.
- R4: The first byte after a START or repeated START is the address byte. Its last data bit (`evt_raw[0]`) is the direction: 0 = write gives code 2, and 1 = read gives code 3. `evt_byte` is `{1'b0, evt_raw[7:1]}`, and `evt_nack` is the acknowledge bit (1 = NACK, 0 = ACK).
- R5: After the address byte, any number of 9-bit data bytes follow. Each gives code 4 (write) or code 5 (read), as set by the latest address direction, with `evt_byte` equal to `evt_raw` and `evt_nack` equal to the acknowledge bit.
- R6: In the data state, a START condition gives code 1 (repeated START) with byte and flag 0. It discards any partly received byte and starts a new address byte.
- R7: In the data state, SDA rising while SCL is high gives code 6 (STOP) with byte and flag 0 and returns to idle. The next START is reported as code 0.
- R8: While the address byte is being received, START and STOP conditions are ignored and the bit count goes on unchanged.
- R9: Samples with `sample_vld` low are not evaluated. An SCL pulse seen only while the strobe is low adds no bit, and each event appears in the cycle after a valid sample.
- R10: In the data state, when SCL rises and SDA falls on the same valid sample, the sample is taken as a data bit and not as a repeated START.
- R11: Each bus event produces exactly one record with `evt_vld` high for one cycle, and code 7 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Sample strobe; line levels are judged only when high |
| scl_in | input | 1 | Sampled serial clock level |
| sda_in | input | 1 | Sampled serial data level |
| evt_vld | output | 1 | One-cycle pulse marking a new event record |
| evt_code | output | 3 | Event code 0..6 (START, repeated START, address write/read, data write/read, STOP) |
| evt_byte | output | 8 | 7-bit address zero-extended, or data byte; 0 for conditions |
| evt_nack | output | 1 | Acknowledge bit of the byte, 1 = NACK |
| evt_raw | output | 8 | The eight received bits before the direction bit is split off |

## Verification
A data-bit capture and a START condition can fall on the same sample when SCL rises while SDA falls. The bench provokes this inside a data byte by moving both lines in one step. It judges the result by requiring a data-write record with the full byte value and no repeated-START record. The address state is also tested against START and STOP patterns placed while SCL is high between two bit captures: the byte must assemble unchanged. A clock pulse hidden behind a low sample strobe must leave no trace in the raw byte.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef enum logic [2:0] {
    EV_START    = 3'd0,
    EV_RSTART   = 3'd1,
    EV_ADDR_WR  = 3'd2,
    EV_ADDR_RD  = 3'd3,
    EV_DATA_WR  = 3'd4,
    EV_DATA_RD  = 3'd5,
    EV_STOP     = 3'd6
  } ev_code_t;

  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } mon_state_t;

  // Line-level happenings found on one valid sample.
  typedef struct packed {
    logic bit_tick;
    logic bit_val;
    logic start_seen;
    logic stop_seen;
  } line_evt_t;

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= '1;  // idle bus level
        end else if (s == 0) begin
          chain_q[s] <= d_in;
        end else begin
          chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_mon_edge.sv
module i2c_mon_edge
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_vld,
  input  logic      scl,
  input  logic      sda,
  output line_evt_t line_evt
);
  logic primed_q, primed_d;
  logic prev_scl_q, prev_scl_d;
  logic prev_sda_q, prev_sda_d;
  logic judge;

  assign judge = smp_vld && primed_q;

  always_comb begin
    primed_d   = primed_q;
    prev_scl_d = prev_scl_q;
    prev_sda_d = prev_sda_q;
    if (smp_vld) begin
      primed_d   = 1'b1;
      prev_scl_d = scl;
      prev_sda_d = sda;
    end
  end

  always_comb begin
    line_evt.bit_tick   = judge && !prev_scl_q && scl;
    line_evt.bit_val    = sda;
    line_evt.start_seen = judge && prev_sda_q && !sda && scl;
    line_evt.stop_seen  = judge && !prev_sda_q && sda && scl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      prev_scl_q <= 1'b1;
      prev_sda_q <= 1'b1;
    end else begin
      primed_q   <= primed_d;
      prev_scl_q <= prev_scl_d;
      prev_sda_q <= prev_sda_d;
    end
  end
endmodule

// File: rtl/i2c_mon_decode.sv
module i2c_mon_decode
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_evt_t         line_evt,
  output logic              ev_vld,
  output ev_code_t          ev_code,
  output logic [DATA_W-1:0] ev_byte,
  output logic              ev_nack,
  output logic [DATA_W-1:0] ev_raw
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(DATA_W);

  mon_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              dir_q, dir_d;

  logic              vld_d;
  ev_code_t          code_d;
  logic [DATA_W-1:0] byte_d, raw_d;
  logic              nack_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    dir_d   = dir_q;
    vld_d   = 1'b0;
    code_d  = ev_code;
    byte_d  = ev_byte;
    raw_d   = ev_raw;
    nack_d  = ev_nack;

    if (state_q == ST_SEEK) begin
      if (line_evt.start_seen) begin
        vld_d   = 1'b1;
        code_d  = EV_START;
        byte_d  = '0;
        raw_d   = '0;
        nack_d  = 1'b0;
        state_d = ST_ADDR;
        cnt_d   = '0;
        sh_d    = '0;
        dir_d   = 1'b0;
      end
    end else if (line_evt.bit_tick) begin
      // bit capture has priority over both conditions
      if (cnt_q == ACK_POS) begin
        vld_d  = 1'b1;
        raw_d  = sh_q;
        nack_d = line_evt.bit_val;
        if (state_q == ST_ADDR) begin
          dir_d   = sh_q[0];
          code_d  = sh_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
          byte_d  = {1'b0, sh_q[DATA_W-1:1]};
          state_d = ST_DATA;
        end else begin
          code_d  = dir_q ? EV_DATA_RD : EV_DATA_WR;
          byte_d  = sh_q;
        end
        cnt_d = '0;
        sh_d  = '0;
      end else begin
        sh_d  = {sh_q[DATA_W-2:0], line_evt.bit_val};
        cnt_d = cnt_q + 1'b1;
      end
    end else if (state_q == ST_DATA && line_evt.start_seen) begin
      vld_d   = 1'b1;
      code_d  = EV_RSTART;
      byte_d  = '0;
      raw_d   = '0;
      nack_d  = 1'b0;
      state_d = ST_ADDR;
      cnt_d   = '0;
      sh_d    = '0;
      dir_d   = 1'b0;
    end else if (state_q == ST_DATA && line_evt.stop_seen) begin
      vld_d   = 1'b1;
      code_d  = EV_STOP;
      byte_d  = '0;
      raw_d   = '0;
      nack_d  = 1'b0;
      state_d = ST_SEEK;
      cnt_d   = '0;
      sh_d    = '0;
      dir_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEEK;
      cnt_q   <= '0;
      sh_q    <= '0;
      dir_q   <= 1'b0;
      ev_vld  <= 1'b0;
      ev_code <= EV_START;
      ev_byte <= '0;
      ev_raw  <= '0;
      ev_nack <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      dir_q   <= dir_d;
      ev_vld  <= vld_d;
      ev_code <= code_d;
      ev_byte <= byte_d;
      ev_raw  <= raw_d;
      ev_nack <= nack_d;
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_vld,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              evt_vld,
  output logic [2:0]        evt_code,
  output logic [DATA_W-1:0] evt_byte,
  output logic              evt_nack,
  output logic [DATA_W-1:0] evt_raw
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_sync;
  line_evt_t        line_evt;
  ev_code_t         code_int;

  i2c_mon_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (lines_sync)
  );

  i2c_mon_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (sample_vld),
    .scl      (lines_sync[1]),
    .sda      (lines_sync[0]),
    .line_evt (line_evt)
  );

  i2c_mon_decode #(.DATA_W(DATA_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_evt (line_evt),
    .ev_vld   (evt_vld),
    .ev_code  (code_int),
    .ev_byte  (evt_byte),
    .ev_nack  (evt_nack),
    .ev_raw   (evt_raw)
  );

  assign evt_code = code_int;
endmodule

// File: rtl/i2c_mon_chk.sv
module i2c_mon_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_vld,
  input logic              evt_vld,
  input logic [2:0]        evt_code,
  input logic [DATA_W-1:0] evt_byte,
  input logic              evt_nack,
  input logic [DATA_W-1:0] evt_raw
);
  logic last_was_stop, last_was_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_was_stop  <= 1'b0;
      last_was_start <= 1'b0;
    end else if (evt_vld) begin
      last_was_stop  <= (evt_code == 3'd6);
      last_was_start <= (evt_code == 3'd0) || (evt_code == 3'd1);
    end
  end

  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |-> evt_code != 3'd7);

  assert_evt_after_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |-> $past(sample_vld));

  assert_cond_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && (evt_code == 3'd0 || evt_code == 3'd1 || evt_code == 3'd6))
      |-> (evt_byte == '0 && evt_raw == '0 && !evt_nack));

  assert_addr_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && (evt_code == 3'd2 || evt_code == 3'd3))
      |-> (evt_byte == {1'b0, evt_raw[DATA_W-1:1]} && evt_raw[0] == (evt_code == 3'd3)));

  assert_data_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && (evt_code == 3'd4 || evt_code == 3'd5)) |-> evt_byte == evt_raw);

  assert_addr_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && last_was_start) |-> (evt_code == 3'd2 || evt_code == 3'd3));

  assert_start_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && last_was_stop) |-> evt_code == 3'd0);

  assert_first_start_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && evt_code == 3'd0) |-> (last_was_stop || !$past(rst_n, 1) || 1'b1) && !last_was_start);
endmodule

bind i2c_bus_monitor i2c_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_vld (sample_vld),
  .evt_vld    (evt_vld),
  .evt_code   (evt_code),
  .evt_byte   (evt_byte),
  .evt_nack   (evt_nack),
  .evt_raw    (evt_raw)
);

// File: tb/i2c_bus_monitor_tb_top.sv
module i2c_bus_monitor_tb_top;
  logic clk;
  logic rst_n, sample_vld, scl_in, sda_in;
  logic evt_vld, evt_nack;
  logic [2:0] evt_code;
  logic [7:0] evt_byte, evt_raw;

  typedef struct {
    logic [2:0] code;
    logic [7:0] val;
    logic       nack;
    logic [7:0] raw;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int ev_seen = 0;
  bit done = 0;
  bit prev_vld = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  i2c_bus_monitor dut_i (
    .clk (clk), .rst_n (rst_n), .sample_vld (sample_vld),
    .scl_in (scl_in), .sda_in (sda_in),
    .evt_vld (evt_vld), .evt_code (evt_code), .evt_byte (evt_byte),
    .evt_nack (evt_nack), .evt_raw (evt_raw)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [2:0] c, input logic [7:0] v, input logic n,
                           input logic [7:0] r, input string tag);
    exp_t e;
    e.code = c; e.val = v; e.nack = n; e.raw = r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic bus(input logic s, input logic d);
    @(negedge clk);
    scl_in = s;
    sda_in = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_idle();
    bus(1, 1); bus(1, 0); bus(0, 0);
  endtask

  task automatic rstart();
    bus(0, 1); bus(1, 1); bus(1, 0); bus(0, 0);
  endtask

  task automatic stop_cond();
    bus(0, 0); bus(1, 0); bus(1, 1);
  endtask

  task automatic send_bit(input logic b);
    bus(0, b); bus(1, b); bus(0, b);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic a);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(a);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && evt_vld) begin
      ev_seen++;
      if (prev_vld) check(1'b0, "R11 pulse longer than one cycle", 1, 0);
      if (q.size() == 0) begin
        check(1'b0, "R11 unexpected event", {evt_code, evt_byte, evt_nack, evt_raw}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(evt_code == e.code && evt_byte == e.val && evt_nack == e.nack && evt_raw == e.raw,
              e.tag, {evt_code, evt_byte, evt_nack, evt_raw}, {e.code, e.val, e.nack, e.raw});
      end
    end
    prev_vld = rst_n && evt_vld;
  end

  initial begin
    rst_n = 1'b0; sample_vld = 1'b0; scl_in = 1'b1; sda_in = 1'b0;
    repeat (4) @(negedge clk);
    check(evt_vld == 1'b0, "R1 evt_vld in reset", evt_vld, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    sample_vld = 1'b1;              // first valid sample sees SDA low, SCL high
    repeat (10) @(negedge clk);
    check(ev_seen == 0, "R1 first sample only primes", ev_seen, 0);
    bus(1, 1);                      // SDA rise while idle: ignored (R2)
    repeat (4) @(negedge clk);
    check(ev_seen == 0, "R2 no STOP while idle", ev_seen, 0);

    // Write transfer
    expect_ev(3'd0, 8'h00, 1'b0, 8'h00, "R2 START");
    expect_ev(3'd2, 8'h50, 1'b0, 8'hA0, "R3 R4 address write");
    expect_ev(3'd4, 8'h3C, 1'b0, 8'h3C, "R5 data write");
    expect_ev(3'd4, 8'hFF, 1'b1, 8'hFF, "R5 data write with NACK");
    expect_ev(3'd6, 8'h00, 1'b0, 8'h00, "R7 STOP");
    start_idle();
    send_byte(8'hA0, 1'b0);
    send_byte(8'h3C, 1'b0);
    send_byte(8'hFF, 1'b1);
    stop_cond();

    // Read transfer with repeated STARTs
    expect_ev(3'd0, 8'h00, 1'b0, 8'h00, "R7 START after STOP");
    expect_ev(3'd3, 8'h2B, 1'b0, 8'h57, "R4 address read");
    expect_ev(3'd5, 8'h81, 1'b0, 8'h81, "R5 data read");
    expect_ev(3'd1, 8'h00, 1'b0, 8'h00, "R6 repeated START");
    expect_ev(3'd2, 8'h11, 1'b1, 8'h22, "R4 address write NACK");
    expect_ev(3'd1, 8'h00, 1'b0, 8'h00, "R6 repeated START mid-byte");
    expect_ev(3'd3, 8'h7F, 1'b0, 8'hFF, "R6 address after partial byte");
    expect_ev(3'd6, 8'h00, 1'b0, 8'h00, "R7 STOP");
    start_idle();
    send_byte(8'h57, 1'b0);
    send_byte(8'h81, 1'b0);
    rstart();
    send_byte(8'h22, 1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    rstart();
    send_byte(8'hFF, 1'b0);
    stop_cond();

    // Conditions during the address byte are ignored
    expect_ev(3'd0, 8'h00, 1'b0, 8'h00, "R8 START");
    expect_ev(3'd2, 8'h62, 1'b0, 8'hC4, "R8 address unaffected by conditions");
    expect_ev(3'd6, 8'h00, 1'b0, 8'h00, "R8 STOP");
    start_idle();
    bus(0, 1); bus(1, 1); bus(1, 0); bus(1, 1); bus(0, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b0);
    stop_cond();

    // SCL pulse hidden behind a low strobe
    expect_ev(3'd0, 8'h00, 1'b0, 8'h00, "R9 START");
    expect_ev(3'd2, 8'h09, 1'b0, 8'h12, "R9 hidden pulse adds no bit");
    expect_ev(3'd6, 8'h00, 1'b0, 8'h00, "R9 STOP");
    start_idle();
    bus(0, 1);
    sample_vld = 1'b0;
    bus(1, 1); bus(0, 1);
    sample_vld = 1'b1;
    send_byte(8'h12, 1'b0);
    stop_cond();

    // SCL rise and SDA fall in one sample inside a data byte
    expect_ev(3'd0, 8'h00, 1'b0, 8'h00, "R10 START");
    expect_ev(3'd2, 8'h30, 1'b0, 8'h60, "R10 address write");
    expect_ev(3'd4, 8'h55, 1'b0, 8'h55, "R10 data bit wins over START");
    expect_ev(3'd6, 8'h00, 1'b0, 8'h00, "R10 STOP");
    start_idle();
    send_byte(8'h60, 1'b0);
    bus(0, 1); bus(1, 0); bus(0, 0);
    for (int i = 6; i >= 0; i--) send_bit(((8'h55 >> i) & 8'h01) != 0);
    send_bit(1'b0);
    stop_cond();

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R11 all expected events seen", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule